// File: doc/BRIEF.md
# Configurable LFSR Noise Generator

This block is a digital noise source built around a linear-feedback shift register. Its length, its two feedback taps, its output tap and the three bit-combining operations are all chosen when the block comes out of reset. A feedback bit is kept one position above the active data bits. Each advance of the register passes through three configurable combining stages. The first merges the stored feedback bit with an external infeed bit. The second merges the result into the shifted data through an insertion mask. The third mixes two tapped bits to form the next stored feedback bit.

An advance can come from one of four sources: a rising edge of an external shift clock, a falling edge of that clock, a counted burst with one advance per system clock, or a phase accumulator that runs at a fixed internal rate. The result is given as a single noise bit and as a signed level. The level is plus or minus half an amplitude word, with a signed bias word added. A level-configurable soft reset reloads the register from a seed. An enable input silences both outputs without disturbing the register.

Top module: `lfsr_noise_gen`

## Requirements
- R1: All `cfg_*` inputs are captured on every clock edge while `rst_n` is low and held once it is high. After the system reset, the data bits and the stored feedback bit are all zero.
- R2: An advance works on N data bits, where N is the latched length in the range 1 to MAX_LEN. Stage 1 combines the stored feedback bit (first operand) with `feed_in` (second operand) using `cfg_op1`. If the stage 1 result is 1, the insertion value is `cfg_ins_mask` limited to N bits, and otherwise it is zero. Stage 2 combines the insertion value (first operand) with the data shifted left by one and cut to N bits (second operand) using `cfg_op2`, and keeps N bits.
- R3: After an advance, `cfg_op0` combines the bits at `cfg_tap0` and `cfg_tap1` of the new data, and the result becomes the stored feedback bit. In all tap lookups, index N reads the stored feedback bit from before the update, and an index above N reads 0.
- R4: Operation codes: 0 XOR, 1 XNOR, 2 AND, 3 OR, 4 NAND, 5 NOR, 6 first operand, 7 zero. The result is always limited to the stage's bit range.
- R5: The soft reset is active when `clr_in` equals `cfg_clr_high`. In an active cycle, the data loads `seed` limited to N bits, and the feedback bit is recomputed from the taps of the loaded data. No advance takes place in that cycle, and any pending count burst is cancelled.
- R6: In mode 0 the register advances on the clock edge where `shift_clk_in` is first seen high after being low. In mode 1 it advances where `shift_clk_in` is first seen low after being high.
- R7: In mode 2, a `count_load` accepted while idle starts a burst of `count_in` advances, one per following clock edge, and `busy` is high for exactly those cycles. A `count_load` while `busy` is high is ignored.
- R8: In mode 3, `cfg_phase_inc` is added to a PHASE_W-bit accumulator on every clock edge, and each carry out causes one advance. The accumulator keeps running during the soft reset and while `enable` is low.
- R9: `noise_bit` is the bit at `cfg_out_tap` XOR `cfg_invert` while `enable` is high, and 0 while `enable` is low. A low `enable` leaves the register state untouched.
- R10: `level` is +(amplitude>>1) when `noise_bit` is 1 and -(amplitude>>1) when it is 0, plus the signed `bias`. It is 0 while `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | system reset, active low; configuration captured while low |
| cfg_len | input | IDX_W | data length N (1..MAX_LEN) |
| cfg_tap0 | input | IDX_W | first feedback tap index |
| cfg_tap1 | input | IDX_W | second feedback tap index |
| cfg_out_tap | input | IDX_W | output tap index |
| cfg_op0 | input | 3 | feedback tap combining code |
| cfg_op1 | input | 3 | infeed combining code |
| cfg_op2 | input | 3 | insertion combining code |
| cfg_ins_mask | input | MAX_LEN | insertion mask |
| cfg_invert | input | 1 | invert output bit |
| cfg_clr_high | input | 1 | soft reset active level |
| cfg_mode | input | 2 | advance source: 0 rise, 1 fall, 2 count, 3 rate |
| cfg_phase_inc | input | PHASE_W | accumulator increment for mode 3 |
| seed | input | MAX_LEN | value loaded by the soft reset |
| clr_in | input | 1 | soft reset request |
| enable | input | 1 | output enable |
| shift_clk_in | input | 1 | external shift clock for modes 0 and 1 |
| feed_in | input | 1 | infeed bit |
| count_in | input | CNT_W | burst length for mode 2 |
| count_load | input | 1 | start a burst in mode 2 |
| amplitude | input | AMP_W | unsigned amplitude word |
| bias | input | BIAS_W | signed bias word |
| busy | output | 1 | burst in progress |
| noise_bit | output | 1 | noise output bit |
| level | output | LVL_W | signed output level |

## Verification
A soft reset can fall in the same clock cycle as an advance. This happens in count mode when the reset arrives in the middle of a burst, and in the rate mode when it lands on an accumulator carry. The bench creates both cases and expects the reset to win. The reloaded seed must appear with no advance applied, and the burst must end at once. In the rate mode, the advances that come after the reset must keep the accumulator's original timing. A second case is a burst request that arrives while a burst is running. The length of `busy` shows that the request was dropped.

// File: rtl/lfsr_noise_pkg.sv
package lfsr_noise_pkg;

   typedef enum logic [2:0] {
      OP_XOR   = 3'd0,
      OP_XNOR  = 3'd1,
      OP_AND   = 3'd2,
      OP_OR    = 3'd3,
      OP_NAND  = 3'd4,
      OP_NOR   = 3'd5,
      OP_FIRST = 3'd6,
      OP_ZERO  = 3'd7
   } comb_op_e;

   typedef enum logic [1:0] {
      ADV_RISE  = 2'd0,
      ADV_FALL  = 2'd1,
      ADV_COUNT = 2'd2,
      ADV_RATE  = 2'd3
   } adv_mode_e;

   // Single-bit combining stage used by the infeed and tap stages.
   function automatic logic comb_bit(input logic [2:0] op, input logic a, input logic b);
      logic r;
      case (comb_op_e'(op))
         OP_XOR:   r = a ^ b;
         OP_XNOR:  r = ~(a ^ b);
         OP_AND:   r = a & b;
         OP_OR:    r = a | b;
         OP_NAND:  r = ~(a & b);
         OP_NOR:   r = ~(a | b);
         OP_FIRST: r = a;
         default:  r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/lfsr_noise_adv.sv
module lfsr_noise_adv #(
   parameter int CNT_W      = 4,
   parameter int PHASE_W    = 8,
   parameter int SYNC_DEPTH = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode,
   input  logic               clr_act,
   input  logic               shift_clk_in,
   input  logic [CNT_W-1:0]   count_in,
   input  logic               count_load,
   input  logic [PHASE_W-1:0] phase_inc,
   output logic               shift_req,
   output logic               busy
);
   import lfsr_noise_pkg::*;

   logic               sck;
   logic               sck_prev_q;
   logic [CNT_W-1:0]   rem_q;
   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W:0]   phase_sum;

   // Optional synchroniser on the external shift clock.
   generate
      if (SYNC_DEPTH == 0) begin : g_nosync
         assign sck = shift_clk_in;
      end else begin : g_sync
         logic [SYNC_DEPTH-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_DEPTH-2+((SYNC_DEPTH==1)?1:0):0], shift_clk_in};
         end
         assign sck = sync_q[SYNC_DEPTH-1];
      end
   endgenerate

   assign phase_sum = {1'b0, phase_q} + {1'b0, phase_inc};
   assign busy      = (rem_q != '0);

   always_comb begin
      case (adv_mode_e'(mode))
         ADV_RISE:  shift_req = sck & ~sck_prev_q;
         ADV_FALL:  shift_req = ~sck & sck_prev_q;
         ADV_COUNT: shift_req = busy;
         default:   shift_req = phase_sum[PHASE_W];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev_q <= 1'b0;
         phase_q    <= '0;
         rem_q      <= '0;
      end else begin
         sck_prev_q <= sck;
         phase_q    <= phase_sum[PHASE_W-1:0];
         if (clr_act)
            rem_q <= '0;
         else if (busy)
            rem_q <= rem_q - 1'b1;
         else if (adv_mode_e'(mode) == ADV_COUNT && count_load)
            rem_q <= count_in;
      end
   end

   // R7: a running burst only counts down, never reloads
   p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !clr_act) |=> (rem_q == $past(rem_q) - 1'b1));

   // R8: an increment below half the range never gives back-to-back carries
   p_rate_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_mode_e'(mode) == ADV_RATE && shift_req && !phase_inc[PHASE_W-1]) |=> !shift_req);

   // R5: soft reset ends any burst
   p_clr_stops_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_act |=> !busy);

endmodule

// File: rtl/lfsr_noise_core.sv
module lfsr_noise_core #(
   parameter int MAX_LEN = 16,
   parameter int IDX_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_act,
   input  logic               shift,
   input  logic               feed,
   input  logic [IDX_W-1:0]   len,
   input  logic [IDX_W-1:0]   tap0,
   input  logic [IDX_W-1:0]   tap1,
   input  logic [IDX_W-1:0]   out_tap,
   input  logic [2:0]         op0,
   input  logic [2:0]         op1,
   input  logic [2:0]         op2,
   input  logic [MAX_LEN-1:0] ins_mask,
   input  logic [MAX_LEN-1:0] seed,
   output logic               out_raw
);
   import lfsr_noise_pkg::*;

   logic [MAX_LEN-1:0] data_q;
   logic               fb_q;
   logic [MAX_LEN-1:0] lmask, ins_v, shl_v, data_sh, seed_m;
   logic               stage1, fb_sh, fb_rs;

   function automatic logic [MAX_LEN-1:0] comb_vec(input logic [2:0] op,
                                                   input logic [MAX_LEN-1:0] a,
                                                   input logic [MAX_LEN-1:0] b,
                                                   input logic [MAX_LEN-1:0] m);
      logic [MAX_LEN-1:0] r;
      case (comb_op_e'(op))
         OP_XOR:   r = a ^ b;
         OP_XNOR:  r = ~(a ^ b);
         OP_AND:   r = a & b;
         OP_OR:    r = a | b;
         OP_NAND:  r = ~(a & b);
         OP_NOR:   r = ~(a | b);
         OP_FIRST: r = a;
         default:  r = '0;
      endcase
      return r & m;
   endfunction

   // Index N returns the stored feedback bit, above N returns zero.
   function automatic logic pick(input logic [MAX_LEN-1:0] v, input logic fb,
                                 input logic [IDX_W-1:0] idx);
      logic [MAX_LEN-1:0] s;
      s = v >> idx;
      if (idx == len)     return fb;
      else if (idx < len) return s[0];
      else                return 1'b0;
   endfunction

   always_comb begin
      // Wraps to all ones when len equals MAX_LEN.
      lmask   = (MAX_LEN'(1) << len) - MAX_LEN'(1);
      stage1  = comb_bit(op1, fb_q, feed);
      ins_v   = stage1 ? (ins_mask & lmask) : '0;
      shl_v   = (data_q << 1) & lmask;
      data_sh = comb_vec(op2, ins_v, shl_v, lmask);
      fb_sh   = comb_bit(op0, pick(data_sh, fb_q, tap0), pick(data_sh, fb_q, tap1));
      seed_m  = seed & lmask;
      fb_rs   = comb_bit(op0, pick(seed_m, fb_q, tap0), pick(seed_m, fb_q, tap1));
      out_raw = pick(data_q, fb_q, out_tap);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         fb_q   <= 1'b0;
      end else if (clr_act) begin
         data_q <= seed_m;
         fb_q   <= fb_rs;
      end else if (shift) begin
         data_q <= data_sh;
         fb_q   <= fb_sh;
      end
   end

   // R5: soft reset loads the trimmed seed
   p_seed_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_act |=> (data_q == $past(seed & lmask)));

   // R9: without a reset or an advance the state holds
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_act && !shift) |=> ($stable(data_q) && $stable(fb_q)));

   // R2: data never holds bits above the active length
   p_len_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_act || shift) |=> ((data_q & ~$past(lmask)) == '0));

endmodule

// File: rtl/lfsr_noise_level.sv
module lfsr_noise_level #(
   parameter int AMP_W  = 8,
   parameter int BIAS_W = 10,
   parameter int LVL_W  = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic                     bit_in,
   input  logic [AMP_W-1:0]         amplitude,
   input  logic signed [BIAS_W-1:0] bias,
   output logic                     noise_bit,
   output logic signed [LVL_W-1:0]  level
);
   logic signed [LVL_W-1:0] half_s, bias_s, swing_s;

   assign half_s    = signed'(LVL_W'(amplitude >> 1));
   assign bias_s    = LVL_W'(bias);
   assign swing_s   = bit_in ? half_s : -half_s;
   assign noise_bit = enable & bit_in;
   assign level     = enable ? (swing_s + bias_s) : '0;

   // R10: with no bias the sign of the level follows the bit
   p_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && bias == '0 && amplitude > AMP_W'(1)) |-> (level[LVL_W-1] == !noise_bit));

   // R9: disabled output is silent
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!noise_bit && level == '0));

endmodule

// File: rtl/lfsr_noise_gen.sv
module lfsr_noise_gen #(
   parameter int MAX_LEN    = 16,
   parameter int CNT_W      = 4,
   parameter int PHASE_W    = 8,
   parameter int AMP_W      = 8,
   parameter int BIAS_W     = 10,
   parameter int SYNC_DEPTH = 0,
   localparam int IDX_W     = $clog2(MAX_LEN + 1),
   localparam int LVL_W     = ((AMP_W > BIAS_W) ? AMP_W : BIAS_W) + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [IDX_W-1:0]         cfg_len,
   input  logic [IDX_W-1:0]         cfg_tap0,
   input  logic [IDX_W-1:0]         cfg_tap1,
   input  logic [IDX_W-1:0]         cfg_out_tap,
   input  logic [2:0]               cfg_op0,
   input  logic [2:0]               cfg_op1,
   input  logic [2:0]               cfg_op2,
   input  logic [MAX_LEN-1:0]       cfg_ins_mask,
   input  logic                     cfg_invert,
   input  logic                     cfg_clr_high,
   input  logic [1:0]               cfg_mode,
   input  logic [PHASE_W-1:0]       cfg_phase_inc,
   input  logic [MAX_LEN-1:0]       seed,
   input  logic                     clr_in,
   input  logic                     enable,
   input  logic                     shift_clk_in,
   input  logic                     feed_in,
   input  logic [CNT_W-1:0]         count_in,
   input  logic                     count_load,
   input  logic [AMP_W-1:0]         amplitude,
   input  logic signed [BIAS_W-1:0] bias,
   output logic                     busy,
   output logic                     noise_bit,
   output logic signed [LVL_W-1:0]  level
);
   generate
      if (MAX_LEN < 2 || MAX_LEN > 64) begin : g_bad_len
         $error("MAX_LEN must be within 2..64");
      end
      if (CNT_W < 1 || PHASE_W < 2) begin : g_bad_ctrl
         $error("CNT_W must be >= 1 and PHASE_W >= 2");
      end
      if (SYNC_DEPTH < 0) begin : g_bad_sync
         $error("SYNC_DEPTH must not be negative");
      end
   endgenerate

   logic [IDX_W-1:0]   len_q, tap0_q, tap1_q, out_tap_q;
   logic [2:0]         op0_q, op1_q, op2_q;
   logic [MAX_LEN-1:0] ins_mask_q;
   logic               invert_q, clr_high_q;
   logic [1:0]         mode_q;
   logic [PHASE_W-1:0] phase_inc_q;
   logic               clr_act, shift_req, out_raw;

   // Configuration is sampled while the system reset is held.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q       <= cfg_len;
         tap0_q      <= cfg_tap0;
         tap1_q      <= cfg_tap1;
         out_tap_q   <= cfg_out_tap;
         op0_q       <= cfg_op0;
         op1_q       <= cfg_op1;
         op2_q       <= cfg_op2;
         ins_mask_q  <= cfg_ins_mask;
         invert_q    <= cfg_invert;
         clr_high_q  <= cfg_clr_high;
         mode_q      <= cfg_mode;
         phase_inc_q <= cfg_phase_inc;
      end
   end

   assign clr_act = (clr_in == clr_high_q);

   lfsr_noise_adv #(
      .CNT_W(CNT_W), .PHASE_W(PHASE_W), .SYNC_DEPTH(SYNC_DEPTH)
   ) u_adv (
      .clk(clk), .rst_n(rst_n), .mode(mode_q), .clr_act(clr_act),
      .shift_clk_in(shift_clk_in), .count_in(count_in), .count_load(count_load),
      .phase_inc(phase_inc_q), .shift_req(shift_req), .busy(busy)
   );

   lfsr_noise_core #(
      .MAX_LEN(MAX_LEN), .IDX_W(IDX_W)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .clr_act(clr_act), .shift(shift_req), .feed(feed_in),
      .len(len_q), .tap0(tap0_q), .tap1(tap1_q), .out_tap(out_tap_q),
      .op0(op0_q), .op1(op1_q), .op2(op2_q), .ins_mask(ins_mask_q), .seed(seed),
      .out_raw(out_raw)
   );

   lfsr_noise_level #(
      .AMP_W(AMP_W), .BIAS_W(BIAS_W), .LVL_W(LVL_W)
   ) u_level (
      .clk(clk), .rst_n(rst_n), .enable(enable), .bit_in(out_raw ^ invert_q),
      .amplitude(amplitude), .bias(bias), .noise_bit(noise_bit), .level(level)
   );

   // R1: latched length stays in its legal range
   p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q != '0) && (int'(len_q) <= MAX_LEN));

endmodule

// File: tb/sim_lfsr_noise_gen.sv
module sim_lfsr_noise_gen;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0] cfg_len = 5'd8, cfg_tap0 = 5'd7, cfg_tap1 = 5'd5, cfg_out_tap = 5'd3;
   logic [2:0] cfg_op0 = 3'd0, cfg_op1 = 3'd0, cfg_op2 = 3'd3;
   logic [15:0] cfg_ins_mask = 16'h0001;
   logic cfg_invert = 1'b0, cfg_clr_high = 1'b1;
   logic [1:0] cfg_mode = 2'd2;
   logic [7:0] cfg_phase_inc = 8'd64;
   logic [15:0] seed = 16'h00B5;
   logic clr_in = 1'b0, enable = 1'b1, shift_clk_in = 1'b0, feed_in = 1'b0;
   logic [3:0] count_in = 4'd0;
   logic count_load = 1'b0;
   logic [7:0] amplitude = 8'd100;
   logic signed [9:0] bias = 10'sd0;
   logic busy, noise_bit;
   logic signed [11:0] level;

   int checks = 0, errors = 0;
   bit done = 0;
   int m_data, m_rem, m_phase;
   bit m_fb, m_prev;

   always #(CLK_PERIOD/2) clk = ~clk;

   lfsr_noise_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_tap0(cfg_tap0), .cfg_tap1(cfg_tap1),
      .cfg_out_tap(cfg_out_tap), .cfg_op0(cfg_op0), .cfg_op1(cfg_op1), .cfg_op2(cfg_op2),
      .cfg_ins_mask(cfg_ins_mask), .cfg_invert(cfg_invert), .cfg_clr_high(cfg_clr_high),
      .cfg_mode(cfg_mode), .cfg_phase_inc(cfg_phase_inc), .seed(seed), .clr_in(clr_in),
      .enable(enable), .shift_clk_in(shift_clk_in), .feed_in(feed_in), .count_in(count_in),
      .count_load(count_load), .amplitude(amplitude), .bias(bias), .busy(busy),
      .noise_bit(noise_bit), .level(level)
   );

   function automatic int lmask();
      return (1 << int'(cfg_len)) - 1;
   endfunction

   function automatic int bop(int op, int a, int b, int m);
      int r;
      case (op)
         0: r = a ^ b;
         1: r = ~(a ^ b);
         2: r = a & b;
         3: r = a | b;
         4: r = ~(a & b);
         5: r = ~(a | b);
         6: r = a;
         default: r = 0;
      endcase
      return r & m;
   endfunction

   function automatic int bpick(int idx);
      int n = int'(cfg_len);
      if (idx == n) return int'(m_fb);
      if (idx < n) return (m_data >> idx) & 1;
      return 0;
   endfunction

   // Reference model of one system clock edge, from the requirements.
   task automatic model_edge();
      bit clr, sh;
      int sum, f1, ins, shl;
      clr = (clr_in == cfg_clr_high);
      sum = m_phase + int'(cfg_phase_inc);
      case (int'(cfg_mode))
         0: sh = shift_clk_in && !m_prev;
         1: sh = !shift_clk_in && m_prev;
         2: sh = (m_rem != 0);
         default: sh = (sum >= 256);
      endcase
      if (clr) begin
         m_data = int'(seed) & lmask();
         m_fb = bop(int'(cfg_op0), bpick(int'(cfg_tap0)), bpick(int'(cfg_tap1)), 1) != 0;
      end else if (sh) begin
         f1 = bop(int'(cfg_op1), int'(m_fb), int'(feed_in), 1);
         ins = (f1 != 0) ? (int'(cfg_ins_mask) & lmask()) : 0;
         shl = (m_data << 1) & lmask();
         m_data = bop(int'(cfg_op2), ins, shl, lmask());
         m_fb = bop(int'(cfg_op0), bpick(int'(cfg_tap0)), bpick(int'(cfg_tap1)), 1) != 0;
      end
      if (clr) m_rem = 0;
      else if (m_rem != 0) m_rem = m_rem - 1;
      else if (cfg_mode == 2'd2 && count_load) m_rem = int'(count_in);
      m_prev = shift_clk_in;
      m_phase = sum & 255;
   endtask

   task automatic cyc();
      model_edge();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_int(int act, int exp, string tag, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      int eb, h, el;
      eb = enable ? (bpick(int'(cfg_out_tap)) ^ int'(cfg_invert)) : 0;
      h = int'(amplitude) >> 1;
      el = enable ? (((eb != 0) ? h : -h) + int'(bias)) : 0;
      expect_int(int'(noise_bit), eb, tag, "noise_bit");
      expect_int(int'(busy), int'(m_rem != 0), tag, "busy");
      expect_int(int'(level), el, tag, "level");
   endtask

   task automatic sys_reset();
      clr_in = ~cfg_clr_high;
      count_load = 1'b0;
      rst_n = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_data = 0; m_fb = 0; m_prev = 0; m_rem = 0; m_phase = 0;
   endtask

   task automatic pulse_clr(string tag);
      clr_in = cfg_clr_high;
      cyc();
      clr_in = ~cfg_clr_high;
      check_all(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: state after system reset, inverted tap of an all-zero register
      cfg_invert = 1'b1;
      sys_reset();
      check_all("R1");
      expect_int(int'(noise_bit), 1, "R1", "zero register inverted");
      cfg_invert = 1'b0;

      // R2 R3 R4: sweep of combining codes in count mode
      cfg_mode = 2'd2;
      cfg_len = 5'd7;
      for (int o0 = 0; o0 < 8; o0++) begin
         for (int o2 = 0; o2 < 8; o2++) begin
            for (int k = 0; k < 3; k++) begin
               cfg_op0 = 3'(o0);
               cfg_op2 = 3'(o2);
               cfg_op1 = (k == 0) ? 3'd0 : ((k == 1) ? 3'd3 : 3'd6);
               cfg_tap0 = 5'd6;
               cfg_tap1 = (k == 2) ? 5'd7 : 5'(((o0 + k) % 6));
               cfg_out_tap = 5'(((o0 + o2 + k) % 9));
               cfg_ins_mask = (o0 == 7) ? 16'h0041 : 16'h0001;
               seed = 16'(8'h35 + o0 * 16 + o2 + k);
               sys_reset();
               pulse_clr("R5");
               for (int b = 0; b < 3; b++) begin
                  count_in = 4'd5;
                  count_load = 1'b1;
                  cyc();
                  count_load = 1'b0;
                  for (int c = 0; c < 6; c++) begin
                     feed_in = ((o0 + o2 + c + b) % 3) == 0;
                     cyc();
                     check_all("R2 R3 R4");
                  end
               end
            end
         end
      end

      // R6: edge modes, rising then falling
      cfg_len = 5'd9; cfg_tap0 = 5'd8; cfg_tap1 = 5'd4; cfg_out_tap = 5'd0;
      cfg_op0 = 3'd0; cfg_op1 = 3'd0; cfg_op2 = 3'd3; cfg_ins_mask = 16'h0001;
      seed = 16'h0123;
      for (int md = 0; md < 2; md++) begin
         cfg_mode = 2'(md);
         sys_reset();
         pulse_clr("R5");
         for (int i = 0; i < 48; i++) begin
            shift_clk_in = (((i / 2) % 2) ^ ((i / 7) % 2)) != 0;
            feed_in = (i % 5) == 1;
            cyc();
            check_all("R6");
         end
      end
      shift_clk_in = 1'b0;

      // R8 R9: rate mode, disabled stretch and a mid-run soft reset
      cfg_mode = 2'd3;
      for (int pi = 0; pi < 2; pi++) begin
         cfg_phase_inc = (pi == 0) ? 8'd64 : 8'd200;
         sys_reset();
         pulse_clr("R5");
         for (int i = 0; i < 40; i++) begin
            enable = !(i >= 10 && i < 20);
            clr_in = (i == 15 || i == 27) ? cfg_clr_high : ~cfg_clr_high;
            cyc();
            check_all(enable ? "R8" : "R9");
         end
         clr_in = ~cfg_clr_high;
         enable = 1'b1;
      end

      // R10: level sweep over amplitude and bias
      cfg_mode = 2'd2;
      sys_reset();
      pulse_clr("R5");
      for (int a = 0; a < 256; a += 15) begin
         for (int bi = 0; bi < 3; bi++) begin
            amplitude = 8'(a);
            bias = (bi == 0) ? -10'sd300 : ((bi == 1) ? 10'sd0 : 10'sd211);
            count_in = 4'd1;
            count_load = (bi == 1);
            cyc();
            check_all("R10");
         end
      end
      count_load = 1'b0;
      amplitude = 8'd100;
      bias = 10'sd0;

      // R5 R7: low-active soft reset, load while busy, reset during a burst
      cfg_clr_high = 1'b0;
      sys_reset();
      pulse_clr("R5");
      count_in = 4'd3;
      count_load = 1'b1;
      cyc();
      check_all("R7");
      count_in = 4'd7;
      for (int i = 0; i < 5; i++) begin
         count_load = (i < 2);
         cyc();
         check_all("R7");
      end
      count_load = 1'b0;
      count_in = 4'd6;
      count_load = 1'b1;
      cyc();
      count_load = 1'b0;
      cyc();
      check_all("R7");
      clr_in = 1'b0;
      cyc();
      clr_in = 1'b1;
      check_all("R5");
      expect_int(int'(busy), 0, "R5", "burst cancelled");
      for (int i = 0; i < 4; i++) begin
         cyc();
         check_all("R5");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule